// File: doc/BRIEF.md
# Power Stage Protection Supervisor

This block guards a half-bridge power stage. It takes three digitized measurements, each with its own valid strobe: the control supply voltage, the die temperature, and the current through the low-side switch. From them it produces a registered run permission for the gate sequencer, a cycle-start inhibit, and a fault flag. The fault flag is active low at the pad and is modelled here as the enable of a pull-down.

Power-on reset uses two thresholds and a deglitch counter, so short undershoots on the supply are ignored. A current sample is only considered while the low-side switch conducts. It is compared against a reference minus a programmable offset. One sample above that limit blocks the next cycle start and latches the drivers off. The latch stays until enable drops or the supply monitor resets. The fault flag is asserted once the over-current state has lasted a qualification time. It is also asserted while the die is too hot. Over-temperature shutdown releases by itself once the temperature has fallen by the hysteresis amount.

Top module: `pstage_guard`

## Requirements
- R1: During and right after synchronous reset, `run_out`, `cycle_inhibit` and `fault_pd_en` are all 0.
- R2: A supply sample at or above VRISE that stays held for POR_DG clock cycles makes the supply good. `run_out` is 1 exactly when the supply is good, enable is high, the over-current latch is clear and the die is not hot. `run_out` rises POR_DG+1 cycles after the edge that captures the sample.
- R3: A supply dip below VFALL that is replaced by a good sample before POR_DG cycles have passed leaves `run_out` unchanged.
- R4: Supply samples between VFALL and VRISE never change the supply state. A sample below VFALL, held for POR_DG cycles, makes the supply bad. `run_out` falls POR_DG+1 cycles after the capturing edge.
- R5: Current samples taken while `ls_on` is 0 are ignored.
- R6: The trip threshold is OC_REF minus `oc_offset`, clamped at 0. Only a qualified sample strictly greater than the threshold counts as over-current. `cycle_inhibit` reflects the latest qualified sample one cycle after the capturing edge.
- R7: An over-current sample latches the drivers off. `run_out` goes to 0 one cycle after the capturing edge and stays 0 after the current falls back.
- R8: `fault_pd_en` goes to 1 when the over-current state has lasted OC_QUAL cycles, that is OC_QUAL+1 cycles after the capturing edge. A shorter episode restarts the count. The flag holds until the latch is cleared.
- R9: `enable_in` low, or a bad supply, clears the latch, the inhibit and the over-current fault. `enable_in` low gives `run_out` 0 at the next edge. Restoring enable, or the supply, brings `run_out` back without any further action.
- R10: A temperature sample at or above T_HOT forces `run_out` to 0 and `fault_pd_en` to 1 one cycle after the capturing edge. A sample below T_HOT does not.
- R11: While hot, samples above T_HOT-T_HYST keep the shutdown. A sample at or below T_HOT-T_HYST releases it one cycle after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_in | input | 1 | Stage enable; low shuts down and clears the over-current latch |
| vsup_vld | input | 1 | Supply sample strobe |
| vsup_code | input | VW | Supply voltage code |
| temp_vld | input | 1 | Temperature sample strobe |
| temp_code | input | TW | Die temperature code |
| isense_vld | input | 1 | Current sample strobe |
| ls_on | input | 1 | Low-side switch conducting; qualifies current samples |
| isense_code | input | CW | Low-side current-sense code |
| oc_offset | input | CW | Programmable amount subtracted from OC_REF |
| run_out | output | 1 | Run permission to the gate sequencer |
| cycle_inhibit | output | 1 | Blocks the start of a new switching cycle |
| fault_pd_en | output | 1 | Drives the fault pull-down (flag active low at the pad) |

## Verification
Each result has a fixed latency, counted from the clock edge that captures the stimulus:
- Temperature and current effects appear one cycle later.
- Enable takes effect at that same edge.
- Run permission after a supply change appears POR_DG+1 cycles later.
- The qualified fault appears OC_QUAL+1 cycles later.

The driver turns every stimulus into expected values tagged with the exact cycle in which they are due. Where a latency matters, it also schedules the opposite value one cycle earlier. The monitor compares these only in their due cycle, so a result that is early or late by one cycle is caught.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {
    SUP_DOWN = 1'b0,
    SUP_GOOD = 1'b1
  } sup_state_t;
endpackage

// File: rtl/pg_supply_mon.sv
module pg_supply_mon
  import pg_pkg::*;
#(
  parameter int VW     = 10,
  parameter int VRISE  = 800,
  parameter int VFALL  = 776,
  parameter int POR_DG = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vs_vld,
  input  logic [VW-1:0] vs_code,
  output logic          sup_ok
);
  localparam int DGW = $clog2(POR_DG + 1);
  localparam logic [VW-1:0] RISE_C = VW'(VRISE);
  localparam logic [VW-1:0] FALL_C = VW'(VFALL);

  logic [VW-1:0]  vs_q;
  logic [DGW-1:0] dg_cnt;
  sup_state_t     st;
  logic           toward;

  // condition pushing the state to flip, depending on the present state
  always_comb begin
    if (st == SUP_DOWN) toward = (vs_q >= RISE_C);
    else                toward = (vs_q <  FALL_C);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q   <= '0;
      dg_cnt <= '0;
      st     <= SUP_DOWN;
    end else begin
      if (vs_vld) vs_q <= vs_code;
      if (toward) begin
        if (dg_cnt == DGW'(POR_DG - 1)) begin
          dg_cnt <= '0;
          st     <= (st == SUP_DOWN) ? SUP_GOOD : SUP_DOWN;
        end else begin
          dg_cnt <= dg_cnt + 1'b1;
        end
      end else begin
        dg_cnt <= '0;
      end
    end
  end

  assign sup_ok = (st == SUP_GOOD);

  p_rise_needs_level_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sup_ok) |-> $past(vs_q >= RISE_C));
  p_fall_needs_level_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sup_ok) |-> $past(vs_q < FALL_C));
  p_dg_bound_r3: assert property (@(posedge clk) disable iff (rst)
    dg_cnt < DGW'(POR_DG));
endmodule

// File: rtl/pg_ocp_unit.sv
module pg_ocp_unit #(
  parameter int CW      = 10,
  parameter int OC_REF  = 190,
  parameter int OC_QUAL = 60000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          is_vld,
  input  logic          ls_on,
  input  logic [CW-1:0] is_code,
  input  logic [CW-1:0] offset,
  output logic          oc_now,
  output logic          oc_latch,
  output logic          oc_fault
);
  localparam int QW = $clog2(OC_QUAL + 1);
  localparam logic [CW-1:0] REF_C = CW'(OC_REF);

  logic [CW:0]    diff;
  logic [CW-1:0]  thr;
  logic           over;
  logic           take;
  logic [QW-1:0]  q_cnt;

  always_comb begin
    diff = {1'b0, REF_C} - {1'b0, offset};
    thr  = diff[CW] ? '0 : diff[CW-1:0];
    over = (is_code > thr);
    take = is_vld && ls_on;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      oc_now   <= 1'b0;
      oc_latch <= 1'b0;
      oc_fault <= 1'b0;
      q_cnt    <= '0;
    end else begin
      if (take) begin
        oc_now <= over;
        if (over) oc_latch <= 1'b1;
      end
      if (oc_now && !oc_fault) begin
        if (q_cnt == QW'(OC_QUAL - 1)) begin
          oc_fault <= 1'b1;
          q_cnt    <= '0;
        end else begin
          q_cnt <= q_cnt + 1'b1;
        end
      end else begin
        q_cnt <= '0;
      end
    end
  end

  p_ls_off_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!ls_on && !clr) |=> $stable(oc_now));
  p_latch_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (oc_latch && !clr) |=> oc_latch);
  p_fault_after_oc_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(oc_fault) |-> $past(oc_now));
  p_clear_all_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!oc_latch && !oc_fault && !oc_now));
endmodule

// File: rtl/pg_thermal_mon.sv
module pg_thermal_mon #(
  parameter int TW     = 8,
  parameter int T_HOT  = 145,
  parameter int T_HYST = 45
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          t_vld,
  input  logic [TW-1:0] t_code,
  output logic          hot
);
  localparam logic [TW-1:0] HOT_C  = TW'(T_HOT);
  localparam logic [TW-1:0] COOL_C = TW'(T_HOT - T_HYST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hot <= 1'b0;
    end else if (t_vld) begin
      if (!hot && t_code >= HOT_C)      hot <= 1'b1;
      else if (hot && t_code <= COOL_C) hot <= 1'b0;
    end
  end

  p_hot_entry_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(hot) |-> $past(t_vld && t_code >= HOT_C));
  p_hot_exit_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(hot) |-> $past(t_vld && t_code <= COOL_C));
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard #(
  parameter int VW      = 10,
  parameter int VRISE   = 800,
  parameter int VFALL   = 776,
  parameter int POR_DG  = 100,
  parameter int CW      = 10,
  parameter int OC_REF  = 190,
  parameter int OC_QUAL = 60000,
  parameter int TW      = 8,
  parameter int T_HOT   = 145,
  parameter int T_HYST  = 45
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable_in,
  input  logic          vsup_vld,
  input  logic [VW-1:0] vsup_code,
  input  logic          temp_vld,
  input  logic [TW-1:0] temp_code,
  input  logic          isense_vld,
  input  logic          ls_on,
  input  logic [CW-1:0] isense_code,
  input  logic [CW-1:0] oc_offset,
  output logic          run_out,
  output logic          cycle_inhibit,
  output logic          fault_pd_en
);
  logic sup_ok, hot, oc_now, oc_latch, oc_fault, clr;

  assign clr = !enable_in || !sup_ok;

  pg_supply_mon #(.VW(VW), .VRISE(VRISE), .VFALL(VFALL), .POR_DG(POR_DG)) u_sup (
    .clk(clk), .rst(rst), .vs_vld(vsup_vld), .vs_code(vsup_code), .sup_ok(sup_ok));

  pg_ocp_unit #(.CW(CW), .OC_REF(OC_REF), .OC_QUAL(OC_QUAL)) u_ocp (
    .clk(clk), .rst(rst), .clr(clr), .is_vld(isense_vld), .ls_on(ls_on),
    .is_code(isense_code), .offset(oc_offset),
    .oc_now(oc_now), .oc_latch(oc_latch), .oc_fault(oc_fault));

  pg_thermal_mon #(.TW(TW), .T_HOT(T_HOT), .T_HYST(T_HYST)) u_thm (
    .clk(clk), .rst(rst), .t_vld(temp_vld), .t_code(temp_code), .hot(hot));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_out       <= 1'b0;
      cycle_inhibit <= 1'b0;
      fault_pd_en   <= 1'b0;
    end else begin
      run_out       <= sup_ok && enable_in && !oc_latch && !hot;
      cycle_inhibit <= oc_now;
      fault_pd_en   <= oc_fault || hot;
    end
  end

  p_run_excludes_fault_r10: assert property (@(posedge clk) disable iff (rst)
    !(run_out && fault_pd_en));
  p_inhibit_stops_run_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_inhibit |-> !run_out);
  p_disable_drops_run_r9: assert property (@(posedge clk) disable iff (rst)
    !enable_in |=> !run_out);
endmodule

// File: tb/test_pstage_guard.sv
module test_pstage_guard;
  localparam int VW = 10, CW = 10, TW = 8;
  localparam int DG = 4, QUAL = 8;

  logic clk = 1'b0, rst = 1'b1, enable_in = 1'b1;
  logic vsup_vld = 1'b0, temp_vld = 1'b0, isense_vld = 1'b0, ls_on = 1'b0;
  logic [VW-1:0] vsup_code = '0;
  logic [TW-1:0] temp_code = 8'd25;
  logic [CW-1:0] isense_code = '0, oc_offset = '0;
  logic run_out, cycle_inhibit, fault_pd_en;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { int due; int sel; logic val; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pstage_guard #(.VW(VW), .VRISE(800), .VFALL(776), .POR_DG(DG), .CW(CW),
    .OC_REF(190), .OC_QUAL(QUAL), .TW(TW), .T_HOT(145), .T_HYST(45)) i_pstage_guard (
    .clk(clk), .rst(rst), .enable_in(enable_in), .vsup_vld(vsup_vld), .vsup_code(vsup_code),
    .temp_vld(temp_vld), .temp_code(temp_code), .isense_vld(isense_vld), .ls_on(ls_on),
    .isense_code(isense_code), .oc_offset(oc_offset), .run_out(run_out),
    .cycle_inhibit(cycle_inhibit), .fault_pd_en(fault_pd_en));

  function automatic logic pick(int sel);
    case (sel)
      0: return run_out;
      1: return cycle_inhibit;
      default: return fault_pd_en;
    endcase
  endfunction

  task automatic chk(int sel, logic val, string tag);
    logic got;
    got = pick(sel);
    checks++;
    if (got !== val) begin
      errors++;
      $display("FAIL %s: output %0d at cycle %0d got %b expected %b", tag, sel, cyc, got, val);
    end
  endtask

  // driver side: expected value due lat cycles from now (0=run,1=inhibit,2=fault)
  task automatic expect_at(int lat, int sel, logic val, string tag);
    exp_t e;
    int idx;
    e.due = cyc + lat; e.sel = sel; e.val = val; e.tag = tag;
    idx = q.size();
    while (idx > 0 && q[idx-1].due > e.due) idx--;
    q.insert(idx, e);
  endtask

  // monitor: compares each expected item in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.sel, e.val, e.tag);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_supply(int code);
    vsup_code = VW'(code); vsup_vld = 1'b1;
  endtask
  task automatic put_temp(int code);
    temp_code = TW'(code); temp_vld = 1'b1;
  endtask
  task automatic put_cur(int code, logic lson);
    isense_code = CW'(code); ls_on = lson; isense_vld = 1'b1;
  endtask
  task automatic release_strobes();
    step(1);
    vsup_vld = 1'b0; temp_vld = 1'b0; isense_vld = 1'b0; ls_on = 1'b0;
  endtask

  initial begin
    step(3);
    chk(0, 1'b0, "R1"); chk(1, 1'b0, "R1"); chk(2, 1'b0, "R1");
    rst = 1'b0;
    step(1);
    chk(0, 1'b0, "R1");
    // R2 power-up
    put_supply(850); expect_at(DG+1, 0, 1'b0, "R2"); expect_at(DG+2, 0, 1'b1, "R2");
    release_strobes(); step(10);
    // R3 short dip ignored
    put_supply(700); release_strobes(); step(1);
    put_supply(850); expect_at(2, 0, 1'b1, "R3"); expect_at(5, 0, 1'b1, "R3");
    expect_at(8, 0, 1'b1, "R3");
    release_strobes(); step(10);
    // R4 between thresholds holds state
    put_supply(790); expect_at(10, 0, 1'b1, "R4"); release_strobes(); step(12);
    // R5 sample with low side off ignored
    oc_offset = 10'd40;
    put_cur(160, 1'b0); expect_at(2, 1, 1'b0, "R5"); expect_at(2, 0, 1'b1, "R5");
    release_strobes(); step(3);
    // R6 equal to threshold is not over
    put_cur(150, 1'b1); expect_at(2, 1, 1'b0, "R6"); expect_at(2, 0, 1'b1, "R6");
    release_strobes(); step(3);
    put_cur(151, 1'b1); expect_at(1, 1, 1'b0, "R6"); expect_at(2, 1, 1'b1, "R6");
    expect_at(2, 0, 1'b0, "R7");
    release_strobes(); step(2);
    // R7 latch survives current falling back; R8 short episode no fault
    put_cur(100, 1'b1); expect_at(2, 1, 1'b0, "R7"); expect_at(6, 0, 1'b0, "R7");
    expect_at(10, 2, 1'b0, "R8");
    release_strobes(); step(12);
    // R8 qualified fault
    put_cur(200, 1'b1); expect_at(QUAL+1, 2, 1'b0, "R8"); expect_at(QUAL+2, 2, 1'b1, "R8");
    expect_at(QUAL+6, 2, 1'b1, "R8");
    release_strobes(); step(QUAL+8);
    // R9 enable low clears everything
    enable_in = 1'b0; expect_at(1, 0, 1'b0, "R9"); expect_at(2, 2, 1'b0, "R9");
    expect_at(2, 1, 1'b0, "R9");
    step(3);
    enable_in = 1'b1; expect_at(1, 0, 1'b1, "R9");
    step(3);
    // R6 threshold clamps at zero
    oc_offset = 10'd250;
    put_cur(0, 1'b1); expect_at(2, 1, 1'b0, "R6"); release_strobes(); step(3);
    put_cur(1, 1'b1); expect_at(2, 1, 1'b1, "R6"); expect_at(2, 0, 1'b0, "R6");
    release_strobes(); step(2);
    // R9 supply loss clears the latch
    put_supply(770); expect_at(4, 1, 1'b1, "R9"); expect_at(8, 1, 1'b0, "R9");
    release_strobes(); step(10);
    put_supply(850); expect_at(DG+2, 0, 1'b1, "R9"); release_strobes(); step(10);
    // R10 over-temperature
    put_temp(144); expect_at(2, 0, 1'b1, "R10"); expect_at(2, 2, 1'b0, "R10");
    release_strobes(); step(3);
    put_temp(145); expect_at(2, 0, 1'b0, "R10"); expect_at(2, 2, 1'b1, "R10");
    release_strobes(); step(3);
    // R11 hysteresis and restart
    put_temp(101); expect_at(3, 0, 1'b0, "R11"); expect_at(3, 2, 1'b1, "R11");
    release_strobes(); step(4);
    put_temp(100); expect_at(1, 0, 1'b0, "R11"); expect_at(2, 0, 1'b1, "R11");
    expect_at(2, 2, 1'b0, "R11");
    release_strobes(); step(4);
    // R4 falling below lower level
    put_supply(775); expect_at(DG+1, 0, 1'b1, "R4"); expect_at(DG+2, 0, 1'b0, "R4");
    release_strobes(); step(10);
    while (q.size() > 0) step(1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule